// File: doc/BRIEF.md
# Short and Long Branch/Skip Unit

This block carries out the control-flow opcodes of an 8-bit processor. It covers the short-branch group, whose high nibble is 0x3, and the long branch and long skip group, whose high nibble is 0xC. The surrounding core hands over three things on a one-cycle `start` pulse: the opcode, the program-counter register R(P) and the condition sources. The condition sources are the accumulator D, the carry flag DF, the output latch Q, the interrupt-enable bit IE and four external flag pins. On `start`, R(P) already points at the byte that follows the opcode.

The unit then reads the immediate bytes at R(P) through a simple memory port. That port has a combinational read: `mem_data` must be valid in the same cycle as `mem_addr`. From those bytes and the captured conditions it works out the next value of R(P). When it finishes it raises `done` for one cycle and presents the new R(P) together with the number of machine cycles the instruction used, counting the opcode fetch.

Low-nibble bit 3 inverts the branch condition. In the long group, low-nibble bit 2 selects the skip variants. Those skips add 2 to R(P), and their condition set includes IE.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_rd`, `rp_out` and `mcycles` are all zero.
- R2: Short-group branch decisions follow the low nibble of the opcode. Low nibble 0 is always taken. Low nibble 1 is taken on Q=1, 2 on D=0 and 3 on DF=1. Low nibbles 4 to 7 are taken when external flag bit 0 to 3 is 1. Low nibbles 9 to F apply the same tests inverted. Low nibble 8 is never taken, which makes it a one-byte skip.
- R3: When a short branch is taken, the low byte of R(P) becomes M(R(P)) and the high byte stays as it was. When it is not taken, R(P) becomes R(P)+1, modulo 2^16.
- R4: Long branches are opcodes 0xC0–0xC3 and 0xC8–0xCB. 0xC0 is always taken, 0xC1 is taken on Q=1, 0xC2 on D=0 and 0xC3 on DF=1. 0xC8 to 0xCB are the inverses, so 0xC8 is never taken. A taken long branch loads R(P) with {M(R(P)), M(R(P)+1)}. One that is not taken leaves R(P)+2.
- R5: Long skips are opcodes 0xC5–0xC7 and 0xCC–0xCF. They skip on the following conditions: 0xC5 on Q=0, 0xC6 on D≠0, 0xC7 on DF=0, 0xCC on IE=1, 0xCD on Q=1, 0xCE on D=0 and 0xCF on DF=1. A skip gives R(P)+2; otherwise R(P) is unchanged. 0xC4 always leaves R(P) unchanged.
- R6: `done` rises one cycle after an accepted short-group `start` and reports `mcycles`=2. For every 0xCN opcode, whether its branch or skip is taken or not, `done` rises two cycles after `start` and reports `mcycles`=3.
- R7: In the first cycle after an accepted `start`, `mem_rd` is 1 and `mem_addr` is R(P). In the second cycle of a 0xCN opcode, `mem_rd` is 1 and `mem_addr` is R(P)+1.
- R8: The opcode, R(P) and all condition inputs are captured at `start`. Any change to them afterwards has no effect on the result.
- R9: A `start` is ignored while `busy` is 1. A `start` whose opcode high nibble is neither 0x3 nor 0xC is also ignored: it produces no `done` and leaves `rp_out` unchanged.
- R10: `done` lasts exactly one cycle. `rp_out` and `mcycles` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin executing `opcode` |
| opcode | input | 8 | Control-flow opcode |
| rp_in | input | 16 | R(P), pointing past the opcode |
| d_in | input | 8 | Accumulator D |
| df_in | input | 1 | Carry flag DF |
| q_in | input | 1 | Output latch Q |
| ie_in | input | 1 | Interrupt enable IE |
| ef_in | input | 4 | External flags, bit 0 is flag 1 |
| mem_addr | output | 16 | Read address for immediate bytes |
| mem_rd | output | 1 | Read strobe |
| mem_data | input | 8 | Byte at `mem_addr`, same cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rp_out | output | 16 | Updated R(P) |
| mcycles | output | 2 | Machine cycles used, including the fetch |

## Verification
The bench aims at the places where a wrong decode goes unnoticed in ordinary code. It runs the inverted forms 0x38 and 0xC8, where a swapped polarity would branch instead of skipping. It runs the irregular 0xC4, which a regular decode would treat as a skip on IE=0. It checks that IE steers only the long skips, so an IE-driven short branch would be caught.

It starts short branches at addresses ending in 0xFF. An adder that drops the carry fails the not-taken case there, and a branch that rewrites the high byte fails the taken case. A long branch that is not taken at 0xFFFF must wrap to 0x0001.

Condition inputs are scrambled, and a second `start` is sent, while an instruction is still running. A design that reads live inputs, or that accepts a start while busy, would then report a wrong R(P) or an extra `done`.

// File: rtl/bru_pkg.sv
// Shared constants and types for the branch/skip unit.
// Assumes one-byte opcodes with the group in the high nibble.
package bru_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;
    localparam int NUM_EF = 4;
    localparam int CYC_W  = 2;
    localparam int SEL_W  = 3;

    localparam logic [3:0] GRP_SHORT = 4'h3;
    localparam logic [3:0] GRP_LONG  = 4'hC;
    localparam logic [3:0] LO_NOP    = 4'h4;

    typedef enum logic [1:0] {
        K_NONE,
        K_SHORT,
        K_LBR,
        K_LSKIP
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EX1,
        ST_EX2
    } state_t;

    typedef struct packed {
        logic [DATA_W-1:0] d;
        logic              df;
        logic              q;
        logic              ie;
        logic [NUM_EF-1:0] ef;
    } cond_t;
endpackage

// File: rtl/bru_decode.sv
// Opcode classifier: splits the opcode into an instruction kind, a
// polarity bit and a condition selector. Purely combinational.
// Assumes only the high nibble 0x3 or 0xC is meaningful.
module bru_decode
    import bru_pkg::*;
(
    input  logic [7:0]       opcode,
    output kind_t            kind,
    output logic             invert,
    output logic [SEL_W-1:0] sel,
    output logic             is_nop
);
    // Classify by group, then split the long group on low-nibble bit 2.
    always_comb begin
        kind   = K_NONE;
        invert = opcode[3];
        sel    = opcode[2:0];
        is_nop = 1'b0;
        if (opcode[7:4] == GRP_SHORT) begin
            kind = K_SHORT;
        end else if (opcode[7:4] == GRP_LONG) begin
            kind   = opcode[2] ? K_LSKIP : K_LBR;
            is_nop = (opcode[3:0] == LO_NOP);
        end
    end
endmodule

// File: rtl/bru_cond.sv
// Condition evaluator: picks the tested flag and applies polarity.
// Skips use the opposite polarity sense to branches, and the long
// skip set tests IE where branches test "always".
module bru_cond
    import bru_pkg::*;
(
    input  kind_t            kind,
    input  logic             invert,
    input  logic [SEL_W-1:0] sel,
    input  logic             is_nop,
    input  cond_t            cnd,
    output logic             take
);
    logic base;

    // Select the raw condition source from the selector bits.
    always_comb begin
        base = 1'b0;
        case (sel[1:0])
            2'd0:    base = (kind == K_LSKIP) ? cnd.ie : 1'b1;
            2'd1:    base = cnd.q;
            2'd2:    base = (cnd.d == '0);
            default: base = cnd.df;
        endcase
        if (kind == K_SHORT && sel[2]) begin
            base = cnd.ef[sel[1:0]];
        end
    end

    // Apply polarity: skips act when the invert bit is set on the source.
    always_comb begin
        case (kind)
            K_SHORT, K_LBR: take = base ^ invert;
            K_LSKIP:        take = is_nop ? 1'b0 : (base ^ ~invert);
            default:        take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_nextpc.sv
// Next-R(P) former. For long branches, hi_byte holds the byte read in
// the first execute cycle and rd_byte the byte being read now.
module bru_nextpc
    import bru_pkg::*;
(
    input  kind_t             kind,
    input  logic              take,
    input  logic [ADDR_W-1:0] rp,
    input  logic [DATA_W-1:0] hi_byte,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] rp_next
);
    // Choose between page jump, full jump, step and hold.
    always_comb begin
        case (kind)
            K_SHORT: rp_next = take ? {rp[ADDR_W-1:DATA_W], rd_byte} : ADDR_W'(rp + 1'b1);
            K_LBR:   rp_next = take ? {hi_byte, rd_byte} : ADDR_W'(rp + 2'd2);
            K_LSKIP: rp_next = take ? ADDR_W'(rp + 2'd2) : rp;
            default: rp_next = rp;
        endcase
    end
endmodule

// File: rtl/branch_skip_unit.sv
// Branch/skip execution unit. Accepts one opcode per start pulse while
// idle, reads immediates over a same-cycle memory port and reports the
// next R(P) with a one-cycle done. Short group: one execute cycle.
// Long group: two execute cycles, always.
module branch_skip_unit
    import bru_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] rp_in,
    input  logic [DATA_W-1:0] d_in,
    input  logic              df_in,
    input  logic              q_in,
    input  logic              ie_in,
    input  logic [NUM_EF-1:0] ef_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] rp_out,
    output logic [CYC_W-1:0]  mcycles
);
    state_t            state;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] rp_q;
    cond_t             cond_q;
    logic [DATA_W-1:0] hi_q;
    logic [CYC_W-1:0]  cnt;

    kind_t            kind_q;
    logic             inv_q;
    logic [SEL_W-1:0] sel_q;
    logic             nop_q;
    logic             take;
    logic [ADDR_W-1:0] rp_next;
    logic             accept;

    bru_decode u_decode (
        .opcode (op_q),
        .kind   (kind_q),
        .invert (inv_q),
        .sel    (sel_q),
        .is_nop (nop_q)
    );

    bru_cond u_cond (
        .kind   (kind_q),
        .invert (inv_q),
        .sel    (sel_q),
        .is_nop (nop_q),
        .cnd    (cond_q),
        .take   (take)
    );

    bru_nextpc u_nextpc (
        .kind    (kind_q),
        .take    (take),
        .rp      (rp_q),
        .hi_byte (hi_q),
        .rd_byte (mem_data),
        .rp_next (rp_next)
    );

    // Accept only idle starts carrying a control-flow group opcode.
    assign accept = start && (state == ST_IDLE) &&
                    ((opcode[7:4] == GRP_SHORT) || (opcode[7:4] == GRP_LONG));

    assign busy   = (state != ST_IDLE);
    assign mem_rd = busy;

    // Address the immediate byte for the current execute cycle.
    always_comb begin
        case (state)
            ST_EX2:  mem_addr = ADDR_W'(rp_q + 1'b1);
            default: mem_addr = rp_q;
        endcase
    end

    // Sequencer: capture, execute one or two cycles, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            rp_q    <= '0;
            cond_q  <= '0;
            hi_q    <= '0;
            cnt     <= '0;
            done    <= 1'b0;
            rp_out  <= '0;
            mcycles <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q   <= opcode;
                        rp_q   <= rp_in;
                        cond_q <= '{d: d_in, df: df_in, q: q_in, ie: ie_in, ef: ef_in};
                        cnt    <= CYC_W'(1);
                        state  <= ST_EX1;
                    end
                end
                ST_EX1: begin
                    cnt <= CYC_W'(cnt + 1'b1);
                    if (kind_q == K_SHORT) begin
                        rp_out  <= rp_next;
                        mcycles <= CYC_W'(cnt + 1'b1);
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        hi_q  <= mem_data;
                        state <= ST_EX2;
                    end
                end
                ST_EX2: begin
                    rp_out  <= rp_next;
                    mcycles <= CYC_W'(cnt + 1'b1);
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: short group finishes after one execute cycle with count 2.
    a_r6_short_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX1 && kind_q == K_SHORT) |=> (done && mcycles == CYC_W'(2)));

    // R6: long group is still running after its first execute cycle.
    a_r6_long_midway: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX1 && kind_q != K_SHORT) |=> (!done && busy));

    // R6: long group finishes after its second execute cycle with count 3.
    a_r6_long_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX2) |=> (done && mcycles == CYC_W'(3)));

    // R7: the second immediate read follows the first one.
    a_r7_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX2) |-> (mem_rd && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: result holds between completions.
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rp_out));

    // R9: the captured opcode does not move while an instruction runs.
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));

    // R3: a short-group result keeps the page of R(P).
    a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX1 && kind_q == K_SHORT && take) |=>
        (rp_out[ADDR_W-1:DATA_W] == $past(rp_q[ADDR_W-1:DATA_W])));

    // R5: the no-operation long opcode leaves R(P) where it was.
    a_r5_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX2 && op_q == {GRP_LONG, LO_NOP}) |=> (rp_out == $past(rp_q)));
endmodule

// File: tb/test_branch_skip_unit.sv
module test_branch_skip_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode;
    logic [15:0] rp_in;
    logic [7:0]  d_in;
    logic        df_in, q_in, ie_in;
    logic [3:0]  ef_in;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data;
    logic        busy, done;
    logic [15:0] rp_out;
    logic [1:0]  mcycles;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Deterministic memory contents computed from the address.
    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] * 8'd7 + 8'h5A);
    endfunction

    assign mem_data = mem_fn(mem_addr);

    branch_skip_unit i_branch_skip_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .rp_in(rp_in), .d_in(d_in), .df_in(df_in), .q_in(q_in),
        .ie_in(ie_in), .ef_in(ef_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_data(mem_data), .busy(busy), .done(done), .rp_out(rp_out),
        .mcycles(mcycles)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected next R(P) from the requirement tables (R2..R5).
    function automatic logic [15:0] exp_rp(input logic [7:0] op, input logic [15:0] rp,
                                           input logic [7:0] d, input logic df, input logic q,
                                           input logic ie, input logic [3:0] ef);
        logic t;
        logic dz;
        dz = (d == 8'h00);
        t  = 1'b0;
        case (op)
            8'h30: t = 1'b1;   8'h31: t = q;      8'h32: t = dz;     8'h33: t = df;
            8'h34: t = ef[0];  8'h35: t = ef[1];  8'h36: t = ef[2];  8'h37: t = ef[3];
            8'h38: t = 1'b0;   8'h39: t = !q;     8'h3A: t = !dz;    8'h3B: t = !df;
            8'h3C: t = !ef[0]; 8'h3D: t = !ef[1]; 8'h3E: t = !ef[2]; 8'h3F: t = !ef[3];
            8'hC0: t = 1'b1;   8'hC1: t = q;      8'hC2: t = dz;     8'hC3: t = df;
            8'hC8: t = 1'b0;   8'hC9: t = !q;     8'hCA: t = !dz;    8'hCB: t = !df;
            8'hC4: t = 1'b0;   8'hC5: t = !q;     8'hC6: t = !dz;    8'hC7: t = !df;
            8'hCC: t = ie;     8'hCD: t = q;      8'hCE: t = dz;     8'hCF: t = df;
            default: t = 1'b0;
        endcase
        if (op[7:4] == 4'h3)
            return t ? {rp[15:8], mem_fn(rp)} : rp + 16'd1;
        else if (op[2] == 1'b0)
            return t ? {mem_fn(rp), mem_fn(rp + 16'd1)} : rp + 16'd2;
        else
            return t ? rp + 16'd2 : rp;
    endfunction

    // Run one opcode; optionally disturb inputs and send a start while busy (R8, R9).
    task automatic run_op(input logic [7:0] op, input logic [15:0] rp, input logic [7:0] d,
                          input logic df, input logic q, input logic ie, input logic [3:0] ef,
                          input bit disturb);
        logic [15:0] exp;
        bit          lng;
        logic [31:0] r;
        exp = exp_rp(op, rp, d, df, q, ie, ef);
        lng = (op[7:4] == 4'hC);
        @(negedge clk);
        opcode = op; rp_in = rp; d_in = d; df_in = df; q_in = q; ie_in = ie; ef_in = ef;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            r = $urandom();
            d_in = r[7:0]; df_in = ~df; q_in = ~q; ie_in = ~ie; ef_in = ~ef;
            rp_in = r[23:8]; opcode = {r[24] ? 4'h3 : 4'hC, r[28:25]};
            start = 1'b1;
        end
        chk(mem_rd && mem_addr == rp, "R7 first read", {15'd0, mem_rd, mem_addr}, {16'd1, rp});
        chk(!done && busy, "R6 not done after one cycle", {31'd0, done}, 32'd0);
        if (lng) begin
            @(negedge clk);
            start = 1'b0;
            chk(mem_rd && mem_addr == rp + 16'd1, "R7 second read", {15'd0, mem_rd, mem_addr}, {16'd1, rp + 16'd1});
            chk(!done, "R6 long not done after two cycles", {31'd0, done}, 32'd0);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R6 done timing", {31'd0, done}, 32'd1);
        chk(mcycles == (lng ? 2'd3 : 2'd2), "R6 mcycles", {30'd0, mcycles}, lng ? 32'd3 : 32'd2);
        chk(rp_out == exp, lng ? "R4/R5 long result" : "R2/R3 short result", {16'd0, rp_out}, {16'd0, exp});
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(!done && rp_out == exp, "R10/R9 hold, single done", {15'd0, done, rp_out}, {16'd0, exp});
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] s;
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; opcode = 8'h00; rp_in = 16'h0;
        d_in = 8'h0; df_in = 1'b0; q_in = 1'b0; ie_in = 1'b0; ef_in = 4'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_rd && rp_out == 16'h0 && mcycles == 2'd0, "R1 reset",
            {busy, done, mem_rd, rp_out, mcycles}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && rp_out == 16'h0, "R1 after release", {busy, done, rp_out}, 32'd0);

        // R2/R3 directed: page-end addresses, polarity pairs, one-byte skip
        run_op(8'h32, 16'h12FF, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // R3 taken keeps page
        run_op(8'h32, 16'h12FF, 8'h01, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // R3 not taken carries
        run_op(8'h3A, 16'h0420, 8'h01, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // R2 inverted D
        run_op(8'h38, 16'h0500, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0); // R2 skip one
        run_op(8'h30, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // R2 always
        run_op(8'h36, 16'h3000, 8'h00, 1'b0, 1'b0, 1'b1, 4'h4, 1'b0); // R2 flag 3
        run_op(8'h30, 16'h3100, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0); // R2 IE unused in short
        // R4 directed
        run_op(8'hC0, 16'h2000, 8'h55, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
        run_op(8'hC8, 16'hFFFF, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0); // R4 never, wraps
        run_op(8'hCB, 16'h00FF, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
        // R5 directed
        run_op(8'hC4, 16'h4444, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // nop, IE=0
        run_op(8'hCC, 16'h4444, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0);
        run_op(8'hCC, 16'h4444, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
        run_op(8'hC6, 16'hFFFE, 8'h80, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
        // R8/R9 directed disturbance
        run_op(8'hC2, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
        run_op(8'h3B, 16'h56FF, 8'h10, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1);

        // R9: opcode outside both groups is ignored
        s = {16'd0, rp_out};
        @(negedge clk);
        opcode = 8'h45; rp_in = 16'hBEEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!busy && !done && rp_out == s[15:0], "R9 foreign opcode ignored", {busy, done, rp_out}, s);
            @(negedge clk);
        end

        // Random mix over both groups (R2..R8)
        for (int i = 0; i < 400; i++) begin
            r = $urandom();
            s = $urandom();
            run_op({r[0] ? 4'h3 : 4'hC, r[4:1]}, s[15:0],
                   r[5] ? 8'h00 : r[13:6], r[14], r[15], r[16], r[20:17], r[21]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule